// File: doc/BRIEF.md
# Tiered Boot Image Fallback Selector

This block is a root-of-trust state machine that decides which firmware image the platform runs after each warm reset. It does no signature checking itself. It asks an external verifier to judge one slot at a time, in a fixed order: read/write slot A, then read/write slot B, then the read-only recovery slot as the last resort. The first slot that passes is reported on the selected-slot output and boot-go is raised. If every candidate fails, the block raises halt and boot-go stays low.

A detector or software can request recovery mode at any time. The request sets a flag that survives warm reset, and the next boot then verifies only the recovery slot. If the booted image later reports a boot failure, the block drops boot-go and sets a rollback flag. It also marks that read/write slot as bad, so that the next boot falls back to the previous stable image. The flags and the bad-slot marks are cleared only by power-on reset, or by a software clear that is accepted while an image is running.

Top module: `boot_slot_selector`

## Requirements
- R1: Slot codes are A = 0, B = 1 and recovery = 2. After warm reset the slots are verified in the order A, B, recovery, and the first one that passes drives `sel_slot_o` with `boot_go_o` high.
- R2: During a verification step, `vfy_req_o` stays high with `vfy_slot_o` stable until `vfy_done_i` is seen. `vfy_pass_i` is sampled in the same cycle as `vfy_done_i`.
- R3: A step with no `vfy_done_i` counts as a fail. In that case `vfy_req_o` is high for exactly `VFY_TIMEOUT` cycles before the next slot is tried.
- R4: When the recovery slot fails, `halt_o` goes high and stays high until the next warm reset, and `boot_go_o` stays low.
- R5: A pulse on `recov_req_i` sets `recov_mode_o`. While the flag is set, a boot verifies only the recovery slot.
- R6: `boot_fail_i` while `boot_go_o` is high drops `boot_go_o` and sets `rollback_o` in the next cycle. A failed A or B slot is skipped on later boots. The recovery slot is never skipped.
- R7: `recov_mode_o`, `rollback_o` and the bad-slot marks keep their values through `rst_ni` and are cleared only by `por_ni`.
- R8: `flag_clr_i` clears both flags and the bad-slot marks only while `boot_go_o` is high. At any other time it has no effect, and a set in the same cycle takes priority over the clear.
- R9: `sel_slot_o` does not change while `boot_go_o` stays high.
- R10: `halt_o` and `boot_go_o` are never high together.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous warm reset; restarts the selection |
| por_ni | input | 1 | Active-low asynchronous power-on reset; also clears sticky state |
| recov_req_i | input | 1 | Request recovery mode for the next boot |
| boot_fail_i | input | 1 | The running image failed to boot |
| flag_clr_i | input | 1 | Software clear of the sticky flags |
| vfy_done_i | input | 1 | Verifier finished the current slot |
| vfy_pass_i | input | 1 | Verifier result, valid with vfy_done_i |
| vfy_req_o | output | 1 | Verification request |
| vfy_slot_o | output | 2 | Slot under verification |
| sel_slot_o | output | 2 | Selected slot |
| boot_go_o | output | 1 | Release the platform to boot sel_slot_o |
| halt_o | output | 1 | No valid image; platform halted |
| recov_mode_o | output | 1 | Sticky recovery-mode flag |
| rollback_o | output | 1 | Sticky rollback flag |

## Verification
A wrong internal state shows up at the ports within one verification step. A stale bad-slot mark or recovery flag puts the wrong code on `vfy_slot_o` in the first request after warm reset. A bad timeout count changes the length of the request pulse. A lost flag shows on `recov_mode_o` or `rollback_o` in the cycle after the reset or clear. Each boot is therefore compared with the slot that a model of the fallback order predicts, and the flags are compared after every warm reset, failure, clear and power-on.

// File: rtl/boot_sel_pkg.sv
package boot_sel_pkg;
  typedef enum logic [1:0] {
    SLOT_A   = 2'd0,
    SLOT_B   = 2'd1,
    SLOT_REC = 2'd2
  } slot_e;

  typedef enum logic [2:0] {
    ST_PICK,
    ST_VFY,
    ST_GAP,
    ST_BOOT,
    ST_FAIL,
    ST_HALT
  } state_e;

  localparam int NUM_RW = 2;
endpackage

// File: rtl/vfy_timer.sv
module vfy_timer #(
  parameter int TIMEOUT = 64
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic run_i,
  output logic expired_o
);
  localparam int CW = $clog2(TIMEOUT + 1);
  localparam logic [CW-1:0] LAST = CW'(TIMEOUT - 1);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       cnt_q <= '0;
    else if (!run_i)   cnt_q <= '0;
    else if (cnt_q != LAST) cnt_q <= cnt_q + 1'b1;
  end

  assign expired_o = run_i && (cnt_q == LAST);
endmodule

// File: rtl/boot_flag_store.sv
module boot_flag_store
  import boot_sel_pkg::*;
#(
  parameter int N_RW = NUM_RW
) (
  input  logic            clk_i,
  input  logic            por_ni,
  input  logic            set_recov_i,
  input  logic            set_fail_i,
  input  logic [1:0]      fail_slot_i,
  input  logic            clr_i,
  output logic            recov_o,
  output logic            rollback_o,
  output logic [N_RW-1:0] skip_o
);
  logic recov_q, roll_q;

  always_ff @(posedge clk_i or negedge por_ni) begin
    if (!por_ni) begin
      recov_q <= 1'b0;
      roll_q  <= 1'b0;
    end else begin
      if (set_recov_i) recov_q <= 1'b1;
      else if (clr_i)  recov_q <= 1'b0;
      if (set_fail_i)  roll_q  <= 1'b1;
      else if (clr_i)  roll_q  <= 1'b0;
    end
  end

  for (genvar i = 0; i < N_RW; i++) begin : g_skip
    logic skip_q;
    always_ff @(posedge clk_i or negedge por_ni) begin
      if (!por_ni) skip_q <= 1'b0;
      else if (set_fail_i && (fail_slot_i == 2'(i))) skip_q <= 1'b1;
      else if (clr_i) skip_q <= 1'b0;
    end
    assign skip_o[i] = skip_q;
  end

  assign recov_o    = recov_q;
  assign rollback_o = roll_q;
endmodule

// File: rtl/slot_order.sv
module slot_order
  import boot_sel_pkg::*;
(
  input  slot_e       cur_i,
  input  logic [1:0]  skip_i,
  input  logic        recov_i,
  output slot_e       first_o,
  output slot_e       next_o,
  output logic        last_o
);
  always_comb begin
    if (recov_i)         first_o = SLOT_REC;
    else if (!skip_i[0]) first_o = SLOT_A;
    else if (!skip_i[1]) first_o = SLOT_B;
    else                 first_o = SLOT_REC;
  end

  always_comb begin
    if (cur_i == SLOT_A && !skip_i[1]) next_o = SLOT_B;
    else                               next_o = SLOT_REC;
  end

  assign last_o = (cur_i == SLOT_REC);
endmodule

// File: rtl/boot_slot_selector.sv
module boot_slot_selector
  import boot_sel_pkg::*;
#(
  parameter int VFY_TIMEOUT = 64
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       por_ni,
  input  logic       recov_req_i,
  input  logic       boot_fail_i,
  input  logic       flag_clr_i,
  input  logic       vfy_done_i,
  input  logic       vfy_pass_i,
  output logic       vfy_req_o,
  output logic [1:0] vfy_slot_o,
  output logic [1:0] sel_slot_o,
  output logic       boot_go_o,
  output logic       halt_o,
  output logic       recov_mode_o,
  output logic       rollback_o
);
  state_e state_q;
  slot_e  cur_q, first_s, next_s;
  logic   last_s, expired_s, recov_s, roll_s;
  logic [NUM_RW-1:0] skip_s;
  logic   in_boot, fail_evt, clr_evt;

  assign in_boot  = (state_q == ST_BOOT);
  assign fail_evt = in_boot && boot_fail_i;
  assign clr_evt  = in_boot && flag_clr_i && !boot_fail_i;

  boot_flag_store #(.N_RW(NUM_RW)) u_flags (
    .clk_i       (clk_i),
    .por_ni      (por_ni),
    .set_recov_i (recov_req_i),
    .set_fail_i  (fail_evt),
    .fail_slot_i (cur_q),
    .clr_i       (clr_evt),
    .recov_o     (recov_s),
    .rollback_o  (roll_s),
    .skip_o      (skip_s)
  );

  slot_order u_order (
    .cur_i   (cur_q),
    .skip_i  (skip_s),
    .recov_i (recov_s),
    .first_o (first_s),
    .next_o  (next_s),
    .last_o  (last_s)
  );

  vfy_timer #(.TIMEOUT(VFY_TIMEOUT)) u_timer (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .run_i     (state_q == ST_VFY),
    .expired_o (expired_s)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_PICK;
      cur_q   <= SLOT_A;
    end else begin
      unique case (state_q)
        ST_PICK: begin
          cur_q   <= first_s;
          state_q <= ST_VFY;
        end
        ST_VFY: begin
          if (vfy_done_i && vfy_pass_i) begin
            state_q <= ST_BOOT;
          end else if (vfy_done_i || expired_s) begin
            if (last_s) begin
              state_q <= ST_HALT;
            end else begin
              cur_q   <= next_s;
              state_q <= ST_GAP;
            end
          end
        end
        ST_GAP:  state_q <= ST_VFY;
        ST_BOOT: if (boot_fail_i) state_q <= ST_FAIL;
        ST_FAIL: state_q <= ST_FAIL;
        ST_HALT: state_q <= ST_HALT;
        default: state_q <= ST_HALT;
      endcase
    end
  end

  assign vfy_req_o    = (state_q == ST_VFY);
  assign vfy_slot_o   = cur_q;
  assign sel_slot_o   = cur_q;
  assign boot_go_o    = in_boot;
  assign halt_o       = (state_q == ST_HALT);
  assign recov_mode_o = recov_s;
  assign rollback_o   = roll_s;
endmodule

// File: rtl/boot_slot_selector_chk.sv
module boot_slot_selector_chk #(
  parameter int VFY_TIMEOUT = 64
) (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       por_ni,
  input logic       boot_fail_i,
  input logic       flag_clr_i,
  input logic       vfy_done_i,
  input logic       vfy_req_o,
  input logic [1:0] vfy_slot_o,
  input logic [1:0] sel_slot_o,
  input logic       boot_go_o,
  input logic       halt_o,
  input logic       rollback_o
);
  localparam int CW = $clog2(VFY_TIMEOUT + 2);
  logic [CW-1:0] req_cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        req_cnt_q <= '0;
    else if (vfy_req_o) req_cnt_q <= req_cnt_q + 1'b1;
    else                req_cnt_q <= '0;
  end

  a_r2_req_hold: assert property (@(posedge clk_i) disable iff (!rst_ni || !por_ni)
    (vfy_req_o && !vfy_done_i && (req_cnt_q < CW'(VFY_TIMEOUT - 1)))
      |=> (vfy_req_o && $stable(vfy_slot_o)));

  a_r3_req_window: assert property (@(posedge clk_i) disable iff (!rst_ni || !por_ni)
    vfy_req_o |-> (req_cnt_q < CW'(VFY_TIMEOUT)));

  a_r4_halt_hold: assert property (@(posedge clk_i) disable iff (!rst_ni || !por_ni)
    halt_o |=> (halt_o && !boot_go_o));

  a_r6_fail_rollback: assert property (@(posedge clk_i) disable iff (!rst_ni || !por_ni)
    (boot_go_o && boot_fail_i) |=> (rollback_o && !boot_go_o));

  a_r7_rollback_sticky: assert property (@(posedge clk_i) disable iff (!por_ni)
    (rollback_o && !(flag_clr_i && boot_go_o)) |=> rollback_o);

  a_r9_sel_stable: assert property (@(posedge clk_i) disable iff (!rst_ni || !por_ni)
    boot_go_o |=> (!boot_go_o || $stable(sel_slot_o)));

  a_r10_exclusive: assert property (@(posedge clk_i) disable iff (!rst_ni || !por_ni)
    !(halt_o && boot_go_o));
endmodule

bind boot_slot_selector boot_slot_selector_chk #(.VFY_TIMEOUT(VFY_TIMEOUT)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .por_ni      (por_ni),
  .boot_fail_i (boot_fail_i),
  .flag_clr_i  (flag_clr_i),
  .vfy_done_i  (vfy_done_i),
  .vfy_req_o   (vfy_req_o),
  .vfy_slot_o  (vfy_slot_o),
  .sel_slot_o  (sel_slot_o),
  .boot_go_o   (boot_go_o),
  .halt_o      (halt_o),
  .rollback_o  (rollback_o)
);

// File: tb/boot_slot_selector_bench.sv
`timescale 1ns/1ps
module boot_slot_selector_bench;
  localparam int TO = 16;

  logic clk = 1'b0;
  logic rst_ni = 1'b0, por_ni = 1'b0;
  logic recov_req_i = 1'b0, boot_fail_i = 1'b0, flag_clr_i = 1'b0;
  logic vfy_done_i = 1'b0, vfy_pass_i = 1'b0;
  logic vfy_req_o, boot_go_o, halt_o, recov_mode_o, rollback_o;
  logic [1:0] vfy_slot_o, sel_slot_o;

  int checks = 0, fails = 0;
  int beh[3];          // 0 pass, 1 fail, 2 no answer
  int lat = 0;
  int req_a_cyc = 0;
  int wait_cnt = 0;
  bit m_recov = 0, m_roll = 0;
  bit [1:0] m_skip = '0;
  bit done_flag = 0;

  always #2 clk = ~clk;

  boot_slot_selector #(.VFY_TIMEOUT(TO)) u_boot_slot_selector (
    .clk_i(clk), .rst_ni(rst_ni), .por_ni(por_ni),
    .recov_req_i(recov_req_i), .boot_fail_i(boot_fail_i), .flag_clr_i(flag_clr_i),
    .vfy_done_i(vfy_done_i), .vfy_pass_i(vfy_pass_i),
    .vfy_req_o(vfy_req_o), .vfy_slot_o(vfy_slot_o), .sel_slot_o(sel_slot_o),
    .boot_go_o(boot_go_o), .halt_o(halt_o),
    .recov_mode_o(recov_mode_o), .rollback_o(rollback_o)
  );

  // verifier model
  initial begin
    forever begin
      @(negedge clk);
      vfy_done_i = 1'b0;
      if (vfy_req_o && rst_ni && beh[vfy_slot_o] != 2) begin
        if (wait_cnt >= lat) begin
          vfy_done_i = 1'b1;
          vfy_pass_i = (beh[vfy_slot_o] == 0);
          wait_cnt = 0;
        end else wait_cnt++;
      end else wait_cnt = 0;
    end
  end

  initial begin
    #400000;
    fails++;
    $display("FAIL watchdog: run hung, actual=running expected=finished");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int exp_outcome();
    if (m_recov) return (beh[2] == 0) ? 2 : 3;
    if (!m_skip[0] && beh[0] == 0) return 0;
    if (!m_skip[1] && beh[1] == 0) return 1;
    if (beh[2] == 0) return 2;
    return 3;
  endfunction

  task automatic pulse(ref logic sig);
    @(negedge clk); sig = 1'b1;
    @(negedge clk); sig = 1'b0;
  endtask

  task automatic check_flags(input string req);
    chk(recov_mode_o == m_recov, {req, " recov flag"}, recov_mode_o, m_recov);
    chk(rollback_o == m_roll, {req, " rollback flag"}, rollback_o, m_roll);
  endtask

  // warm reset, then wait for boot or halt
  task automatic warm_boot(output int outcome);
    @(negedge clk); rst_ni = 1'b0;
    repeat (2) @(negedge clk);
    check_flags("R7 after warm reset");
    rst_ni = 1'b1;
    req_a_cyc = 0;
    outcome = -1;
    for (int i = 0; i < 4 * TO + 40; i++) begin
      @(negedge clk);
      if (vfy_req_o && vfy_slot_o == 2'd0) req_a_cyc++;
      if (boot_go_o) begin outcome = int'(sel_slot_o); break; end
      if (halt_o)    begin outcome = 3; break; end
    end
  endtask

  task automatic run_case(input int b0, input int b1, input int b2, input string req);
    int got, exp;
    beh[0] = b0; beh[1] = b1; beh[2] = b2;
    exp = exp_outcome();
    warm_boot(got);
    chk(got == exp, req, got, exp);
    if (exp == 3) chk(!boot_go_o, "R4 boot_go low on halt", boot_go_o, 0);
  endtask

  initial begin
    int r;
    void'($urandom(32'h5EED_1234));
    beh[0] = 0; beh[1] = 0; beh[2] = 0;
    repeat (3) @(negedge clk);
    chk(!vfy_req_o && !boot_go_o && !halt_o, "reset state outputs", {vfy_req_o, boot_go_o, halt_o}, 0);
    chk(!recov_mode_o && !rollback_o, "R7 por clears flags", {recov_mode_o, rollback_o}, 0);
    por_ni = 1'b1;

    run_case(0, 0, 0, "R1 all pass selects A");
    repeat (10) @(negedge clk);
    chk(boot_go_o && sel_slot_o == 2'd0, "R9 selection held", sel_slot_o, 0);
    run_case(1, 0, 0, "R1 A fails selects B");
    lat = 3;
    run_case(1, 1, 0, "R1 R2 A and B fail selects recovery");
    lat = 0;
    run_case(2, 0, 1, "R3 A timeout selects B");
    chk(req_a_cyc == TO, "R3 request length on timeout", req_a_cyc, TO);
    run_case(1, 2, 1, "R4 all fail halts");
    repeat (20) @(negedge clk);
    chk(halt_o && !boot_go_o, "R4 halt persists", halt_o, 1);

    // boot failure -> rollback, skip A
    run_case(0, 0, 0, "R1 boot A");
    pulse(boot_fail_i);
    m_roll = 1; m_skip[0] = 1;
    chk(!boot_go_o, "R6 boot_go drops on failure", boot_go_o, 0);
    check_flags("R6");
    run_case(0, 0, 0, "R6 failed A skipped, B selected");
    run_case(1, 1, 1, "R4 halt with A skipped");
    pulse(flag_clr_i);
    check_flags("R8 clear ignored while halted");
    run_case(0, 0, 0, "R8 skip kept after ignored clear");

    // recovery mode request
    pulse(recov_req_i);
    m_recov = 1;
    check_flags("R5 request sets flag");
    run_case(0, 0, 0, "R5 recovery forced");
    chk(req_a_cyc == 0, "R5 slot A not requested", req_a_cyc, 0);
    @(negedge clk); flag_clr_i = 1'b1; recov_req_i = 1'b1;
    @(negedge clk); flag_clr_i = 1'b0; recov_req_i = 1'b0;
    m_roll = 0; m_skip = '0;
    check_flags("R8 set wins over clear");
    pulse(flag_clr_i);
    m_recov = 0;
    check_flags("R8 clear while booted");
    run_case(0, 0, 0, "R8 cleared skip, A selected");

    // power-on reset clears sticky state
    pulse(boot_fail_i);
    m_roll = 1; m_skip[0] = 1;
    @(negedge clk); por_ni = 1'b0; rst_ni = 1'b0;
    @(negedge clk); por_ni = 1'b1;
    m_roll = 0; m_skip = '0;
    check_flags("R7 por");
    run_case(0, 0, 0, "R7 por clears skip");

    // random mix
    for (int it = 0; it < 60; it++) begin
      lat = $urandom_range(0, 3);
      run_case(($urandom % 2) ? 0 : $urandom_range(1, 2),
               ($urandom % 2) ? 0 : $urandom_range(1, 2),
               ($urandom % 4) ? 0 : $urandom_range(1, 2), "R1 R5 R6 random boot");
      r = $urandom % 4;
      if (boot_go_o) begin
        if (r == 0) begin
          if (sel_slot_o != 2'd2) m_skip[sel_slot_o] = 1;
          pulse(boot_fail_i); m_roll = 1;
        end else if (r == 1) begin
          pulse(flag_clr_i); m_recov = 0; m_roll = 0; m_skip = '0;
        end else if (r == 2) begin
          pulse(recov_req_i); m_recov = 1;
        end
      end else if (r < 2) begin
        pulse(flag_clr_i);
      end
      check_flags("R6 R8 random flags");
    end

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule